// File: doc/BRIEF.md
# Programmable Sync Pattern Detector

This block sits behind a clock-recovery stage and scans the recovered serial bit stream for the synchronisation character that marks the start of a payload. A bit is taken only in a cycle where the bit-valid strobe is high. Bits enter a shift window most significant bit first, and the window is compared after every bit. The character has two halves. The upper half is the fixed byte 2Dh. The lower half comes from the `pattern_lo` configuration input. With `word_mode` low, only the lower byte has to match. With `word_mode` high, all sixteen bits must match: 2Dh received first, then the programmable byte straight after it.

A match gives a one-cycle `match_pulse` and sets the sticky `synced` flag. From then on the block groups each following run of eight bits into a byte. It presents that byte on `byte_data` with a one-cycle `byte_valid` strobe. Dropping `enable` abandons the frame: the window, its fill count, the byte counter and the flag are all cleared, so the next search starts from an empty window.

The controller has three states. IDLE is the state while disabled. HUNT is the search for the pattern. LOCKED is byte assembly. The transitions are IDLE→HUNT when `enable` is high, HUNT→LOCKED on a valid bit that completes a match, and HUNT→IDLE or LOCKED→IDLE when `enable` is low. IDLE, HUNT and LOCKED otherwise stay where they are.

Top module: `sync_hunter_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `match_pulse`, `synced` and `byte_valid` are 0.
- R2: With `word_mode`=0, a match occurs when the last 8 valid bits equal `pattern_lo`. The first bit received is bit 7.
- R3: With `word_mode`=1, a match occurs when the last 16 valid bits equal {8'h2D, `pattern_lo`}. The 2Dh byte is the earlier one, and the first bit received is bit 15.
- R4: No match is reported until at least 8 valid bits (byte mode) or 16 valid bits (word mode) have been received since hunting began. This holds even when the pattern is all zeros.
- R5: A match is reported by `match_pulse` high for exactly one cycle, just after the clock edge that sampled the completing bit. `synced` becomes 1 at the same edge.
- R6: `synced` stays 1 while `enable` is high, and no further `match_pulse` occurs while synced, even if the pattern reappears.
- R7: Once synced, every 8 further valid bits are output on `byte_data` with the first of the 8 bits in bit 7. `byte_valid` is high for one cycle, just after the edge that sampled the eighth bit.
- R8: Cycles with `bit_valid` low shift nothing, whatever the value of `bit_in`.
- R9: With `enable` low, the block returns to IDLE within one edge: `synced`, `match_pulse` and `byte_valid` go to 0 and bits are ignored. Hunting resumes from an empty window on the cycle after `enable` returns high.
- R10: In word mode, a correct lower byte preceded by a wrong upper byte gives no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Search enable; low clears all state |
| bit_valid | input | 1 | Strobe: `bit_in` is a new recovered bit |
| bit_in | input | 1 | Recovered data bit |
| pattern_lo | input | 8 | Programmable lower pattern byte |
| word_mode | input | 1 | 0: 8-bit pattern, 1: 16-bit pattern {2Dh, pattern_lo} |
| match_pulse | output | 1 | One-cycle pulse on pattern match |
| synced | output | 1 | Sticky synchronised flag |
| byte_data | output | 8 | Assembled payload byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |

## Verification
The bench targets patterns that turn up at an unaligned position. For example, 55h appears inside the stream 2Dh,55h after only 14 bits, and a design that compares only on byte boundaries would report the match late. It uses an all-zero pattern straight after enable, which a design without a fill count would match on the first bit. It sends a wrong upper byte in word mode, which a comparison that checks only the low byte would accept. After lock it checks that the payload is aligned to the bit after the pattern and that a repeated pattern raises no second pulse. It also checks that bits sent while disabled, and cycles where the strobe is idle but `bit_in` toggles, leave no trace.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } hunt_state_t;
endpackage

// File: rtl/sync_shifter.sv
module sync_shifter #(
    parameter int WIN_W = 16,
    localparam int CW = $clog2(WIN_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_next,
    output logic [CW-1:0]    fill_next
);
    localparam logic [CW-1:0] FULL = CW'(WIN_W);

    logic [WIN_W-1:0] win_q;
    logic [CW-1:0]    fill_q;

    always_comb begin
        win_next  = shift ? {win_q[WIN_W-2:0], bit_in} : win_q;
        fill_next = (shift && fill_q != FULL) ? fill_q + 1'b1 : fill_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else begin
            win_q  <= win_next;
            fill_q <= fill_next;
        end
    end
endmodule

// File: rtl/sync_match.sv
module sync_match #(
    parameter int              BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] FIXED_HI = 8'h2D,
    localparam int WIN_W = 2 * BYTE_W,
    localparam int CW    = $clog2(WIN_W + 1)
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [CW-1:0]     fill,
    input  logic [BYTE_W-1:0] pat_lo,
    input  logic              word_mode,
    output logic              hit
);
    localparam logic [CW-1:0] NEED_BYTE = CW'(BYTE_W);
    localparam logic [CW-1:0] NEED_WORD = CW'(WIN_W);

    always_comb begin
        if (word_mode)
            hit = (win == {FIXED_HI, pat_lo}) && (fill >= NEED_WORD);
        else
            hit = (win[BYTE_W-1:0] == pat_lo) && (fill >= NEED_BYTE);
    end
endmodule

// File: rtl/sync_assembler.sv
module sync_assembler #(
    parameter int BYTE_W = 8,
    localparam int CNTW = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam logic [CNTW-1:0] LAST = CNTW'(BYTE_W - 1);

    logic [BYTE_W-2:0] acc_q;
    logic [CNTW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
        end else if (take) begin
            acc_q <= {acc_q[BYTE_W-3:0], bit_in};
            if (cnt_q == LAST) begin
                byte_data  <= {acc_q, bit_in};
                byte_valid <= 1'b1;
                cnt_q      <= '0;
            end else begin
                byte_valid <= 1'b0;
                cnt_q      <= cnt_q + 1'b1;
            end
        end else begin
            byte_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
    import sync_hunt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_valid,
    input  logic hit,
    output logic clr,
    output logic shift,
    output logic take,
    output logic match_pulse,
    output logic synced
);
    hunt_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable) state_d = ST_HUNT;
            ST_HUNT:   if (!enable) state_d = ST_IDLE;
                       else if (bit_valid && hit) state_d = ST_LOCKED;
            ST_LOCKED: if (!enable) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        clr   = !enable;
        shift = enable && bit_valid && (state_q == ST_HUNT);
        take  = enable && bit_valid && (state_q == ST_LOCKED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) match_pulse <= 1'b0;
        else        match_pulse <= shift && hit;
    end

    assign synced = (state_q == ST_LOCKED);

    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
    a_r5_pulse_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> synced);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (synced && enable) |=> synced);
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!synced && !match_pulse));
endmodule

// File: rtl/sync_hunter_top.sv
module sync_hunter_top #(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] FIXED_HI = 8'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [BYTE_W-1:0] pattern_lo,
    input  logic              word_mode,
    output logic              match_pulse,
    output logic              synced,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam int WIN_W = 2 * BYTE_W;
    localparam int CW    = $clog2(WIN_W + 1);

    logic             clr, shift, take, hit;
    logic [WIN_W-1:0] win_next;
    logic [CW-1:0]    fill_next;

    sync_shifter #(.WIN_W(WIN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift(shift), .bit_in(bit_in),
        .win_next(win_next), .fill_next(fill_next)
    );

    sync_match #(.BYTE_W(BYTE_W), .FIXED_HI(FIXED_HI)) u_match (
        .win(win_next), .fill(fill_next), .pat_lo(pattern_lo),
        .word_mode(word_mode), .hit(hit)
    );

    sync_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_valid(bit_valid),
        .hit(hit), .clr(clr), .shift(shift), .take(take),
        .match_pulse(match_pulse), .synced(synced)
    );

    sync_assembler #(.BYTE_W(BYTE_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .bit_in(bit_in),
        .byte_data(byte_data), .byte_valid(byte_valid)
    );

    a_r7_valid_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> synced);
    a_r8_idle_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> (!match_pulse && !byte_valid));
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
endmodule

// File: tb/tb_sync_hunter_top.sv
module tb_sync_hunter_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] pattern_lo = 8'h00;
    logic       word_mode = 1'b0;
    logic       match_pulse, synced, byte_valid;
    logic [7:0] byte_data;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sync_hunter_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_valid(bit_valid),
        .bit_in(bit_in), .pattern_lo(pattern_lo), .word_mode(word_mode),
        .match_pulse(match_pulse), .synced(synced),
        .byte_data(byte_data), .byte_valid(byte_valid)
    );

    // {word_mode, pattern, stream (MSB sent first), bits to send, expected first-match bit (0 = none)}
    localparam int NV = 8;
    localparam logic [52:0] VEC [NV] = '{
        {1'b0, 8'hA5, 32'hA500_0000, 6'd8,  6'd8},
        {1'b0, 8'h81, 32'hFF81_0000, 6'd16, 6'd16},
        {1'b1, 8'h55, 32'h2D55_0000, 6'd16, 6'd16},
        {1'b1, 8'h55, 32'h2C55_2D55, 6'd32, 6'd32},
        {1'b0, 8'h00, 32'h0000_0000, 6'd8,  6'd8},
        {1'b1, 8'h00, 32'h2D00_0000, 6'd16, 6'd16},
        {1'b0, 8'h55, 32'h2D55_0000, 6'd16, 6'd14},
        {1'b1, 8'hA5, 32'hA5A5_A5A5, 6'd32, 6'd0}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic mp, output logic bv, output logic [7:0] bd);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = ~b;
        mp = match_pulse;
        bv = byte_valid;
        bd = byte_data;
    endtask

    task automatic restart();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic mp, bv;
        logic [7:0] bd;
        int first, pulses;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(!match_pulse && !synced && !byte_valid, "R1 in reset",
              {29'd0, match_pulse, synced, byte_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!match_pulse && !synced && !byte_valid, "R1 after reset",
              {29'd0, match_pulse, synced, byte_valid}, 0);

        // Vector table: R2 R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            word_mode  = VEC[v][52];
            pattern_lo = VEC[v][51:44];
            restart();
            first = 0;
            pulses = 0;
            for (int i = 1; i <= int'(VEC[v][11:6]); i++) begin
                send_bit(VEC[v][43 - i + 1], mp, bv, bd);
                if (mp) begin
                    pulses++;
                    if (first == 0) first = i;
                end
            end
            check(first == int'(VEC[v][5:0]), $sformatf("R2 R3 R4 R10 vector %0d match bit", v),
                  first, VEC[v][5:0]);
            check(synced == (VEC[v][5:0] != 0) && pulses == (VEC[v][5:0] != 0 ? 1 : 0),
                  $sformatf("R5 R6 vector %0d synced/pulses", v), {synced, 8'(pulses)},
                  {(VEC[v][5:0] != 0), 8'((VEC[v][5:0] != 0) ? 1 : 0)});
        end

        // R7 byte assembly after lock, R6 no re-match on repeated pattern
        word_mode  = 1'b0;
        pattern_lo = 8'hA5;
        restart();
        for (int i = 7; i >= 0; i--) send_bit(pattern_lo[i], mp, bv, bd);
        check(mp && synced, "R5 lock on A5", {mp, synced}, 2'b11);
        begin
            logic [7:0] payload [3] = '{8'h3C, 8'hA5, 8'h96};
            for (int k = 0; k < 3; k++) begin
                pulses = 0;
                for (int i = 7; i >= 0; i--) begin
                    send_bit(payload[k][i], mp, bv, bd);
                    if (mp) pulses++;
                    if (i != 0) check(!bv, "R7 no early byte_valid", bv, 0);
                end
                check(bv && bd == payload[k], "R7 assembled byte", {bv, bd}, {1'b1, payload[k]});
                check(pulses == 0 && synced, "R6 no pulse while synced", pulses, 0);
            end
        end

        // R9 disable clears and ignores bits
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!synced && !match_pulse && !byte_valid, "R9 cleared on disable",
              {synced, match_pulse, byte_valid}, 0);
        pulses = 0;
        for (int i = 7; i >= 0; i--) begin
            send_bit(pattern_lo[i], mp, bv, bd);
            if (mp || bv) pulses++;
        end
        check(pulses == 0 && !synced, "R9 bits ignored while disabled", pulses, 0);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        first = 0;
        for (int i = 7; i >= 0; i--) begin
            send_bit(pattern_lo[i], mp, bv, bd);
            if (mp && first == 0) first = 8 - i;
        end
        check(first == 8, "R9 fresh search after re-enable", first, 8);

        // R8 idle strobe cycles with toggling data shift nothing
        pattern_lo = 8'hC3;
        restart();
        first = 0;
        for (int i = 7; i >= 4; i--) begin
            send_bit(pattern_lo[i], mp, bv, bd);
            if (mp) first = 8 - i;
        end
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            bit_in = c[0];
            if (match_pulse) first = 99;
        end
        for (int i = 3; i >= 0; i--) begin
            send_bit(pattern_lo[i], mp, bv, bd);
            if (mp && first == 0) first = 8 - i;
        end
        check(first == 8, "R8 idle strobe ignored", first, 8);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule